// File: doc/BRIEF.md
# Coprocessor Multi-Word Transfer Handshake Sequencer

This block sits on the coprocessor side of a pipelined core's coprocessor port. For each coprocessor load or store that moves one or more 32-bit words, it returns a 2-bit handshake code every cycle. The core presents an instruction strobe together with a coprocessor number and a word count. The sequencer answers in one of three ways. It reports that no coprocessor answers when the number is not its own. It stalls the core with WAIT while its own busy input is high. Otherwise it paces the words, driving GO while two or more words remain and LAST when exactly one word remains. LAST tells the core that the next transfer is the final one.

The core decides whether the instruction executes only after the sequencer has started answering, so the sequencer must be able to drop an accepted instruction. When the pass input is low before the first word has moved, the sequencer abandons the instruction and returns to idle. After the first word has moved, the instruction is committed and runs to its end. A per-word advance strobe from the core counts the words down. The memory system, address generation and the data path are outside this block.

Top module: `cop_xfer_seq`

## Requirements
- R1: A synchronous active-low reset puts the sequencer in idle. In idle, with no valid instruction, the handshake output is WAIT (2'b00).
- R2: In idle, a valid instruction whose coprocessor number differs from the parameter COP_ID gives ABSENT (2'b10) in that same cycle. The sequencer stays idle, so the next cycle with no instruction shows WAIT.
- R3: In idle, a valid instruction whose number equals COP_ID is accepted. The output in the acceptance cycle is WAIT, and the word count is loaded. A count of zero is treated as one word.
- R4: From the cycle after acceptance, until the first word moves, the output is WAIT in every cycle where busy is high and pass is high.
- R5: Once the sequencer is not busy-waiting, the output is GO (2'b01) while two or more words remain.
- R6: The output is LAST (2'b11) while exactly one word remains.
- R7: Each advance strobe in a GO or LAST cycle removes one word. An advance strobe in a WAIT cycle has no effect. Without a strobe, the output code holds.
- R8: After an advance strobe in a LAST cycle, the sequencer is idle in the next cycle.
- R9: If pass is low in any cycle after acceptance and before the first word moves, the instruction is cancelled. The output is WAIT in that cycle, and in the next cycle the sequencer is idle with the remaining count cleared. Cancellation takes priority over busy and over the advance strobe.
- R10: Once the first word has moved, busy and pass no longer affect the output.
- R11: While an instruction is in progress, the instruction strobe, coprocessor number and word count are ignored. ABSENT is never shown during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | A coprocessor load/store instruction is presented |
| cp_num | input | ID_W | Coprocessor number of the presented instruction |
| word_cnt | input | CNT_W | Number of words to move (0 means 1) |
| busy | input | 1 | Coprocessor not yet ready to start |
| pass | input | 1 | Core's condition result; low cancels before commit |
| xfer_adv | input | 1 | Core moved one word in this cycle |
| hs_code | output | 2 | Handshake code: WAIT 00, GO 01, ABSENT 10, LAST 11 |

## Verification
The assertions assume that the core raises the advance strobe only in a way the handshake allows. They also assume that every input is at a known level from the first clock edge onward, because the load check compares the loaded count with the word count seen one cycle earlier. The bench drives every input to a defined value from time zero and changes inputs only at falling edges. It takes words only by strobing the advance input. Advance strobes that arrive during WAIT cycles are deliberate, so that the rule that they are ignored is tested. During busy waits and after commit, the bench deliberately drives pass low and busy high, which exercises the cancel and ignore rules without leaving the input space the properties describe.

// File: rtl/cop_hs_pkg.sv
// Shared types for the coprocessor handshake sequencer.
// Assumes: the handshake encoding is fixed by the core's port definition.
package cop_hs_pkg;

    // Handshake codes returned to the core
    typedef enum logic [1:0] {
        HS_WAIT   = 2'b00,
        HS_GO     = 2'b01,
        HS_ABSENT = 2'b10,
        HS_LAST   = 2'b11
    } hs_code_e;

    // Sequencer states: idle, accepted but not committed, committed
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'b00,
        SQ_ARMED = 2'b01,
        SQ_MOVE  = 2'b10
    } seq_state_e;

endpackage

// File: rtl/cop_hs_match.sv
// Compares the presented coprocessor number with this unit's own number.
// Assumes: cp_num is meaningful only while instr_valid is high.
module cop_hs_match #(
    parameter int ID_W   = 4,
    parameter int COP_ID = 5
) (
    input  logic            instr_valid,
    input  logic [ID_W-1:0] cp_num,
    output logic            hit,
    output logic            miss
);
    localparam logic [ID_W-1:0] OWN_ID = ID_W'(COP_ID);

    // Split a valid instruction into "ours" and "someone else's"
    always_comb begin
        hit  = instr_valid && (cp_num == OWN_ID);
        miss = instr_valid && (cp_num != OWN_ID);
    end
endmodule

// File: rtl/cop_hs_count.sv
// Remaining-word counter: loaded on acceptance, decremented per word,
// cleared on cancellation.
// Assumes: load, step and clear are never requested in a way that underflows.
module cop_hs_count #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    input  logic             clear,
    output logic [CNT_W-1:0] rem
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] load_fix;

    // A requested count of zero moves a single word
    always_comb load_fix = (load_val == '0) ? ONE : load_val;

    // Counter update: reset and clear win, then load, then step
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rem <= '0;
        end else if (load) begin
            rem <= load_fix;
        end else if (step) begin
            rem <= rem - ONE;
        end
    end
endmodule

// File: rtl/cop_hs_fsm.sv
// Control state machine: acceptance, busy wait, cancellation, commit and
// completion of a coprocessor multi-word transfer.
// Assumes: rem is non-zero whenever the state is not idle.
module cop_hs_fsm
    import cop_hs_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             busy,
    input  logic             pass,
    input  logic             xfer_adv,
    input  logic [CNT_W-1:0] rem,
    output seq_state_e       state,
    output logic             accept,
    output logic             cancel,
    output logic             drive,
    output logic             step
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    seq_state_e state_nx;
    logic       final_word;

    // Per-cycle control decisions derived from the current state
    always_comb begin
        final_word = (rem == ONE);
        accept     = (state == SQ_IDLE) && hit;
        cancel     = (state == SQ_ARMED) && !pass;
        drive      = ((state == SQ_ARMED) && pass && !busy) || (state == SQ_MOVE);
        step       = drive && xfer_adv;
    end

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_IDLE:  if (accept) state_nx = SQ_ARMED;
            SQ_ARMED: begin
                if (cancel)                  state_nx = SQ_IDLE;
                else if (step && final_word) state_nx = SQ_IDLE;
                else if (step)               state_nx = SQ_MOVE;
            end
            SQ_MOVE:  if (step && final_word) state_nx = SQ_IDLE;
            default:  state_nx = SQ_IDLE;
        endcase
    end

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= state_nx;
    end
endmodule

// File: rtl/cop_hs_encode.sv
// Maps the sequencer condition onto the 2-bit handshake code.
// Assumes: drive is only high outside idle, with rem at least one.
module cop_hs_encode
    import cop_hs_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  seq_state_e       state,
    input  logic             miss,
    input  logic             drive,
    input  logic [CNT_W-1:0] rem,
    output hs_code_e         code
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Code selection: foreign instruction in idle, word pacing, or stall
    always_comb begin
        if (state == SQ_IDLE)  code = miss ? HS_ABSENT : HS_WAIT;
        else if (!drive)       code = HS_WAIT;
        else if (rem > ONE)    code = HS_GO;
        else                   code = HS_LAST;
    end
endmodule

// File: rtl/cop_xfer_seq.sv
// Top of the coprocessor multi-word transfer handshake sequencer.
// Assumes: inputs are synchronous to clk; the core strobes xfer_adv once
// per word moved.
module cop_xfer_seq
    import cop_hs_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int COP_ID = 5,
    parameter int CNT_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [ID_W-1:0]  cp_num,
    input  logic [CNT_W-1:0] word_cnt,
    input  logic             busy,
    input  logic             pass,
    input  logic             xfer_adv,
    output logic [1:0]       hs_code
);
    logic             hit, miss;
    logic             accept, cancel, drive, step;
    logic [CNT_W-1:0] rem_q;
    seq_state_e       state_q;
    hs_code_e         code;

    cop_hs_match #(.ID_W(ID_W), .COP_ID(COP_ID)) u_match (
        .instr_valid (instr_valid),
        .cp_num      (cp_num),
        .hit         (hit),
        .miss        (miss)
    );

    cop_hs_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .busy     (busy),
        .pass     (pass),
        .xfer_adv (xfer_adv),
        .rem      (rem_q),
        .state    (state_q),
        .accept   (accept),
        .cancel   (cancel),
        .drive    (drive),
        .step     (step)
    );

    cop_hs_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (word_cnt),
        .step     (step),
        .clear    (cancel),
        .rem      (rem_q)
    );

    cop_hs_encode #(.CNT_W(CNT_W)) u_enc (
        .state (state_q),
        .miss  (miss),
        .drive (drive),
        .rem   (rem_q),
        .code  (code)
    );

    // Drive the port from the encoded handshake
    always_comb hs_code = code;
endmodule

// File: rtl/cop_xfer_seq_chk.sv
// Property checker for cop_xfer_seq, attached through bind.
// Assumes: all inputs are at known levels from the first clock edge.
module cop_xfer_seq_chk
    import cop_hs_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int COP_ID = 5,
    parameter int CNT_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             instr_valid,
    input logic [ID_W-1:0]  cp_num,
    input logic [CNT_W-1:0] word_cnt,
    input logic             busy,
    input logic             pass,
    input logic             xfer_adv,
    input logic [1:0]       hs_code,
    input seq_state_e       state,
    input logic [CNT_W-1:0] rem
);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
    localparam logic [ID_W-1:0]  OWN_ID = ID_W'(COP_ID);

    // R1
    idle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_IDLE && !instr_valid) |-> hs_code == HS_WAIT);

    // R2
    foreign_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_IDLE && instr_valid && cp_num != OWN_ID) |=> state == SQ_IDLE);

    // R3
    load_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_IDLE && instr_valid && cp_num == OWN_ID) |=>
        (rem == (($past(word_cnt) == '0) ? ONE : $past(word_cnt))));

    // R4
    busy_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_ARMED && busy && pass) |-> hs_code == HS_WAIT);

    // R5
    go_many_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_code == HS_GO) |-> rem > ONE);

    // R6
    last_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_code == HS_LAST) |-> rem == ONE);

    // R7
    go_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_code == HS_GO && xfer_adv) |=> rem == $past(rem) - ONE);

    // R8
    last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_code == HS_LAST && xfer_adv) |=> state == SQ_IDLE);

    // R9
    cancel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_ARMED && !pass) |=> (state == SQ_IDLE && rem == '0));

    // R10
    committed_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_MOVE) |-> (hs_code == HS_GO || hs_code == HS_LAST));

    // R11
    active_no_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SQ_IDLE) |-> hs_code != HS_ABSENT);
endmodule

bind cop_xfer_seq cop_xfer_seq_chk #(
    .ID_W   (ID_W),
    .COP_ID (COP_ID),
    .CNT_W  (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .cp_num      (cp_num),
    .word_cnt    (word_cnt),
    .busy        (busy),
    .pass        (pass),
    .xfer_adv    (xfer_adv),
    .hs_code     (hs_code),
    .state       (state_q),
    .rem         (rem_q)
);

// File: tb/cop_xfer_seq_tb.sv
// Self-checking bench for cop_xfer_seq: a vector table of transfer
// scenarios walked by one loop, then directed reset and corner tests.
module cop_xfer_seq_tb;
    localparam int ID_W   = 4;
    localparam int COP_ID = 5;
    localparam int CNT_W  = 5;
    localparam logic [ID_W-1:0] OWN   = ID_W'(COP_ID);
    localparam logic [ID_W-1:0] OTHER = ID_W'(COP_ID + 1);

    localparam logic [1:0] C_WAIT = 2'b00, C_GO = 2'b01, C_ABS = 2'b10, C_LAST = 2'b11;
    localparam logic [3:0] NO_CANCEL = 4'd15;

    // {count[4:0], busy cycles[3:0], cancel cycle[3:0], gap[1:0], spare}
    localparam int NVEC = 10;
    localparam logic [15:0] VEC [NVEC] = '{
        {5'd1,  4'd0, NO_CANCEL, 2'd0, 1'b0},
        {5'd0,  4'd2, NO_CANCEL, 2'd0, 1'b0},
        {5'd2,  4'd0, NO_CANCEL, 2'd1, 1'b0},
        {5'd5,  4'd3, NO_CANCEL, 2'd0, 1'b0},
        {5'd16, 4'd1, NO_CANCEL, 2'd0, 1'b0},
        {5'd4,  4'd4, 4'd2,      2'd0, 1'b0},
        {5'd3,  4'd0, 4'd0,      2'd0, 1'b0},
        {5'd7,  4'd2, 4'd2,      2'd0, 1'b0},
        {5'd31, 4'd0, NO_CANCEL, 2'd0, 1'b0},
        {5'd9,  4'd5, NO_CANCEL, 2'd2, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             instr_valid = 1'b0;
    logic [ID_W-1:0]  cp_num = '0;
    logic [CNT_W-1:0] word_cnt = '0;
    logic             busy = 1'b0;
    logic             pass = 1'b1;
    logic             xfer_adv = 1'b0;
    logic [1:0]       hs_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    cop_xfer_seq #(.ID_W(ID_W), .COP_ID(COP_ID), .CNT_W(CNT_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .cp_num      (cp_num),
        .word_cnt    (word_cnt),
        .busy        (busy),
        .pass        (pass),
        .xfer_adv    (xfer_adv),
        .hs_code     (hs_code)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [1:0] exp);
        checks++;
        if (hs_code !== exp) begin
            errors++;
            $display("FAIL %s: hs_code=%b expected=%b at %0t", req, hs_code, exp, $time);
        end
    endtask

    // Drive inputs for one cycle at the falling edge
    task automatic drive(input logic iv, input logic [ID_W-1:0] num,
                         input logic [CNT_W-1:0] cnt, input logic b,
                         input logic p, input logic adv);
        @(negedge clk);
        instr_valid = iv; cp_num = num; word_cnt = cnt;
        busy = b; pass = p; xfer_adv = adv;
        #1;
    endtask

    // A foreign instruction shows ABSENT only when the sequencer is idle
    task automatic probe_idle(input string req);
        drive(1'b1, OTHER, 5'd3, 1'b0, 1'b1, 1'b0);
        chk(req, C_ABS);
    endtask

    task automatic run_vec(input logic [4:0] cnt, input logic [3:0] bl,
                           input logic [3:0] ca, input logic [1:0] gap);
        int words;
        logic [1:0] exp;
        words = (cnt == 0) ? 1 : int'(cnt);
        drive(1'b1, OWN, cnt, 1'b0, 1'b1, 1'b0);
        chk("R3 accept", C_WAIT);
        for (int i = 0; i < int'(bl); i++) begin
            // advance strobes during busy wait must be ignored (R7)
            drive(1'b0, OWN, 5'd0, 1'b1, (i != int'(ca)), 1'b1);
            if (i == int'(ca)) begin
                chk("R9 cancel during busy", C_WAIT);
                probe_idle("R9 idle after cancel");
                return;
            end
            chk("R4 busy wait", C_WAIT);
        end
        if (ca == bl) begin
            drive(1'b0, OWN, 5'd0, 1'b0, 1'b0, 1'b1);
            chk("R9 cancel beats advance", C_WAIT);
            probe_idle("R9 idle after cancel");
            return;
        end
        for (int w = words; w >= 1; w--) begin
            exp = (w >= 2) ? C_GO : C_LAST;
            for (int g = 0; g < int'(gap); g++) begin
                drive(1'b0, OWN, 5'd0, (w != words), (w == words), 1'b0);
                chk("R7 hold without advance", exp);
            end
            // after commit, busy high and pass low are ignored (R10)
            drive(1'b0, OWN, 5'd0, (w != words), (w == words), 1'b1);
            chk((w >= 2) ? "R5 GO while many" : "R6 LAST on final", exp);
        end
        probe_idle("R8 idle after last");
    endtask

    initial begin
        // R1 reset with a matching instruction presented
        drive(1'b1, OWN, 5'd4, 1'b0, 1'b1, 1'b0);
        drive(1'b0, OWN, 5'd0, 1'b0, 1'b1, 1'b0);
        drive(1'b0, OWN, 5'd0, 1'b0, 1'b1, 1'b0);
        @(negedge clk); rst_n = 1'b1; #1;
        chk("R1 idle after reset", C_WAIT);

        // R2 foreign number: ABSENT now, still idle next cycle
        drive(1'b1, OTHER, 5'd2, 1'b0, 1'b1, 1'b0);
        chk("R2 foreign ABSENT", C_ABS);
        drive(1'b0, OWN, 5'd0, 1'b0, 1'b1, 1'b0);
        chk("R2 stays idle", C_WAIT);

        for (int v = 0; v < NVEC; v++) begin
            run_vec(VEC[v][15:11], VEC[v][10:7], VEC[v][6:3], VEC[v][2:1]);
        end

        // R11 new instructions ignored while active
        drive(1'b1, OWN, 5'd2, 1'b1, 1'b1, 1'b0);
        chk("R3 accept two", C_WAIT);
        drive(1'b1, OTHER, 5'd9, 1'b1, 1'b1, 1'b0);
        chk("R11 no ABSENT while active", C_WAIT);
        drive(1'b1, OWN, 5'd9, 1'b0, 1'b1, 1'b1);
        chk("R11 count not reloaded", C_GO);
        drive(1'b1, OWN, 5'd9, 1'b0, 1'b1, 1'b0);
        chk("R11 LAST kept", C_LAST);
        drive(1'b1, OTHER, 5'd9, 1'b0, 1'b1, 1'b1);
        chk("R11 LAST with foreign strobe", C_LAST);
        probe_idle("R8 idle after last");

        // R1 reset during a committed transfer
        drive(1'b1, OWN, 5'd3, 1'b0, 1'b1, 1'b0);
        drive(1'b0, OWN, 5'd0, 1'b0, 1'b1, 1'b1);
        chk("R5 first of three", C_GO);
        drive(1'b0, OWN, 5'd0, 1'b0, 1'b1, 1'b0);
        chk("R5 second of three", C_GO);
        @(negedge clk); rst_n = 1'b0; #1;
        @(negedge clk); rst_n = 1'b1; #1;
        chk("R1 reset mid transfer", C_WAIT);
        probe_idle("R1 idle after reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run is a failed check
    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule